// File: doc/BRIEF.md
# UART Automatic Power-Down Controller

This block decides when each half of every UART channel may stop its clock. Each channel has a transmit half and a receive half, and the two halves enter and leave the low-power state on their own. The transmit half sleeps once its holding buffer and shift register have both drained, and it wakes when the host writes a new character. The receive half sleeps once its FIFO is empty and the receiver is idle waiting for a start bit, and it wakes when the serial input changes level. Every half reports its state as a powerdown flag and as a clock-enable that downstream clock gating can use.

Two configuration bits per channel control the block. The force bit puts both halves of the channel into powerdown no matter what the channel is doing. The automatic bit allows the sleep and wake sequencing above. Ring-indicator change detection runs on the always-on clock, so a change on that line raises an interrupt pulse even while the channel is asleep. The serial receive line and the ring-indicator line each pass through a two-flop synchronizer before their edges are detected.

Top module: `uart_pwr_ctrl`

## Requirements
- R1: While `cfg_force_pd[i]` is 1, both `tx_pd[i]` and `rx_pd[i]` are 1 from the next clock edge. A host write or a receive-line change does not wake a forced channel.
- R2: While `cfg_auto_en[i]` is 0 and the force bit is 0, neither half of channel i powers down. Clearing `cfg_auto_en[i]` while a half is in automatic powerdown wakes that half at the next clock edge.
- R3: With automatic management enabled, `tx_pd[i]` rises at the clock edge that ends the second consecutive cycle (ENTRY_HOLD = 2) in which `tx_hold_empty[i]` and `tx_shift_empty[i]` are both 1.
- R4: With automatic management enabled, `rx_pd[i]` rises at the clock edge that ends the second consecutive cycle in which `rx_fifo_empty[i]` and `rx_idle[i]` are both 1.
- R5: An idle condition that lasts fewer than ENTRY_HOLD cycles does not cause powerdown, and a break in it restarts the count.
- R6: A 1 on `tx_wr[i]` clears `tx_pd[i]` at the next clock edge. This holds in automatic powerdown and also in a cycle that would otherwise complete entry.
- R7: A level change on `rxd_async[i]` wakes an automatically powered-down receive half: `rx_pd[i]` falls at the third clock edge after the change (two synchronizer flops plus the state register).
- R8: Any change on `ri_async[i]`, rising or falling, produces a one-cycle pulse on `ri_irq[i]` at the third clock edge after the change, whatever the channel's power state.
- R9: `tx_clk_en[i]` is always the inverse of `tx_pd[i]`, and `rx_clk_en[i]` is always the inverse of `rx_pd[i]`. After reset, all powerdown flags and interrupts are 0 and all clock-enables are 1. The synchronizer flops reset to 1, the idle level of both lines.
- R10: The halves and the channels are independent: one half powering down leaves the other half and the other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_force_pd | input | NUM_CH | Per-channel forced powerdown bit |
| cfg_auto_en | input | NUM_CH | Per-channel automatic management enable |
| tx_hold_empty | input | NUM_CH | Transmit holding buffer empty |
| tx_shift_empty | input | NUM_CH | Transmit shift register empty |
| tx_wr | input | NUM_CH | Host write strobe to transmit holding buffer |
| rx_fifo_empty | input | NUM_CH | Receive FIFO empty |
| rx_idle | input | NUM_CH | Receiver waiting for a start bit |
| rxd_async | input | NUM_CH | Asynchronous serial receive line |
| ri_async | input | NUM_CH | Asynchronous ring-indicator line |
| tx_pd | output | NUM_CH | Transmit half powered down |
| rx_pd | output | NUM_CH | Receive half powered down |
| tx_clk_en | output | NUM_CH | Transmit half clock enable |
| rx_clk_en | output | NUM_CH | Receive half clock enable |
| ri_irq | output | NUM_CH | One-cycle ring-indicator change pulse |

## Verification
The assertions check several rules on every cycle. A forced channel is asleep one edge later. A disabled channel never sleeps. Every automatic rise of a powerdown flag was preceded by two qualifying cycles. A host write always leaves the transmit half awake. The clock-enables always mirror the flags. Only the bench's scenarios can show the exact three-edge latency of the receive-line wake and of the ring-indicator pulse, the count being restarted by a transient, and the independence of halves and channels. The same applies to ring-indicator pulses firing while a channel is forced or asleep.

// File: rtl/uart_pwr_pkg.sv
package uart_pwr_pkg;

  // Power state of one half (transmit or receive) of a channel
  typedef enum logic [1:0] {
    HS_ON     = 2'd0,
    HS_AUTO   = 2'd1,
    HS_FORCED = 2'd2
  } half_state_e;

  // Default qualification window before automatic entry
  localparam int unsigned DEF_ENTRY_HOLD = 2;
  // Default synchronizer depth for asynchronous lines
  localparam int unsigned DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/uart_pwr_sync.sv
// Multi-flop synchronizer followed by a change detector.
module uart_pwr_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic change
);
  // Stages 0..STAGES-1 synchronize; stage STAGES holds the previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= {(STAGES+1){RESET_VAL}};
    end else begin
      sh_q <= {sh_q[STAGES-1:0], d_async};
    end
  end

  assign change = sh_q[STAGES] ^ sh_q[STAGES-1];

endmodule

// File: rtl/uart_pwr_half.sv
// Power sequencer for one half of a channel.
module uart_pwr_half
  import uart_pwr_pkg::*;
#(
  parameter int unsigned ENTRY_HOLD = DEF_ENTRY_HOLD
) (
  input  logic clk,
  input  logic rst,
  input  logic force_pd,
  input  logic auto_en,
  input  logic idle_ok,
  input  logic wake,
  output logic pd,
  output logic clk_en
);
  localparam int unsigned CW = (ENTRY_HOLD > 1) ? $clog2(ENTRY_HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(ENTRY_HOLD - 1);

  half_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pd_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = '0;
    if (force_pd) begin
      state_d = HS_FORCED;
    end else if (!auto_en) begin
      state_d = HS_ON;
    end else if (state_q == HS_AUTO) begin
      state_d = wake ? HS_ON : HS_AUTO;
    end else if (idle_ok && !wake) begin
      // qualifying cycle: count until the hold window is complete
      if (cnt_q == LAST) begin
        state_d = HS_AUTO;
      end else begin
        state_d = HS_ON;
        cnt_d   = cnt_q + CW'(1);
      end
    end else begin
      // activity, a wake strobe or a released force restarts qualification
      state_d = HS_ON;
    end
  end

  assign pd_d = (state_d != HS_ON);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= HS_ON;
      cnt_q   <= '0;
      pd      <= 1'b0;
      clk_en  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pd      <= pd_d;
      clk_en  <= !pd_d;
    end
  end

endmodule

// File: rtl/uart_pwr_ctrl.sv
// Automatic power-down controller for NUM_CH UART channels.
module uart_pwr_ctrl
  import uart_pwr_pkg::*;
#(
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned ENTRY_HOLD  = DEF_ENTRY_HOLD,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] cfg_force_pd,
  input  logic [NUM_CH-1:0] cfg_auto_en,
  input  logic [NUM_CH-1:0] tx_hold_empty,
  input  logic [NUM_CH-1:0] tx_shift_empty,
  input  logic [NUM_CH-1:0] tx_wr,
  input  logic [NUM_CH-1:0] rx_fifo_empty,
  input  logic [NUM_CH-1:0] rx_idle,
  input  logic [NUM_CH-1:0] rxd_async,
  input  logic [NUM_CH-1:0] ri_async,
  output logic [NUM_CH-1:0] tx_pd,
  output logic [NUM_CH-1:0] rx_pd,
  output logic [NUM_CH-1:0] tx_clk_en,
  output logic [NUM_CH-1:0] rx_clk_en,
  output logic [NUM_CH-1:0] ri_irq
);
  logic [NUM_CH-1:0] rxd_chg;
  logic [NUM_CH-1:0] ri_chg;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    uart_pwr_sync #(
      .STAGES   (SYNC_STAGES),
      .RESET_VAL(1'b1)
    ) u_rxd_sync (
      .clk    (clk),
      .rst    (rst),
      .d_async(rxd_async[ch]),
      .change (rxd_chg[ch])
    );

    uart_pwr_sync #(
      .STAGES   (SYNC_STAGES),
      .RESET_VAL(1'b1)
    ) u_ri_sync (
      .clk    (clk),
      .rst    (rst),
      .d_async(ri_async[ch]),
      .change (ri_chg[ch])
    );

    uart_pwr_half #(
      .ENTRY_HOLD(ENTRY_HOLD)
    ) u_tx_half (
      .clk     (clk),
      .rst     (rst),
      .force_pd(cfg_force_pd[ch]),
      .auto_en (cfg_auto_en[ch]),
      .idle_ok (tx_hold_empty[ch] & tx_shift_empty[ch]),
      .wake    (tx_wr[ch]),
      .pd      (tx_pd[ch]),
      .clk_en  (tx_clk_en[ch])
    );

    uart_pwr_half #(
      .ENTRY_HOLD(ENTRY_HOLD)
    ) u_rx_half (
      .clk     (clk),
      .rst     (rst),
      .force_pd(cfg_force_pd[ch]),
      .auto_en (cfg_auto_en[ch]),
      .idle_ok (rx_fifo_empty[ch] & rx_idle[ch]),
      .wake    (rxd_chg[ch]),
      .pd      (rx_pd[ch]),
      .clk_en  (rx_clk_en[ch])
    );

    // Ring-indicator interrupt runs on the always-on clock in every state
    always_ff @(posedge clk) begin
      if (rst) begin
        ri_irq[ch] <= 1'b0;
      end else begin
        ri_irq[ch] <= ri_chg[ch];
      end
    end
  end

endmodule

// File: rtl/uart_pwr_ctrl_chk.sv
module uart_pwr_ctrl_chk #(
  parameter int unsigned NUM_CH = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] cfg_force_pd,
  input logic [NUM_CH-1:0] cfg_auto_en,
  input logic [NUM_CH-1:0] tx_hold_empty,
  input logic [NUM_CH-1:0] tx_shift_empty,
  input logic [NUM_CH-1:0] tx_wr,
  input logic [NUM_CH-1:0] rx_fifo_empty,
  input logic [NUM_CH-1:0] rx_idle,
  input logic [NUM_CH-1:0] rxd_async,
  input logic [NUM_CH-1:0] ri_async,
  input logic [NUM_CH-1:0] tx_pd,
  input logic [NUM_CH-1:0] rx_pd,
  input logic [NUM_CH-1:0] tx_clk_en,
  input logic [NUM_CH-1:0] rx_clk_en,
  input logic [NUM_CH-1:0] ri_irq
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    assert_force_sleeps_R1: assert property (@(posedge clk) disable iff (rst)
      cfg_force_pd[i] |=> (tx_pd[i] && rx_pd[i]));

    assert_no_auto_awake_R2: assert property (@(posedge clk) disable iff (rst)
      (!cfg_auto_en[i] && !cfg_force_pd[i]) |=> (!tx_pd[i] && !rx_pd[i]));

    assert_tx_entry_held_R3: assert property (@(posedge clk) disable iff (rst)
      ($rose(tx_pd[i]) && !$past(cfg_force_pd[i])) |->
        ($past(tx_hold_empty[i] && tx_shift_empty[i], 1) &&
         $past(tx_hold_empty[i] && tx_shift_empty[i], 2)));

    assert_rx_entry_held_R4: assert property (@(posedge clk) disable iff (rst)
      ($rose(rx_pd[i]) && !$past(cfg_force_pd[i])) |->
        ($past(rx_fifo_empty[i] && rx_idle[i], 1) &&
         $past(rx_fifo_empty[i] && rx_idle[i], 2)));

    assert_write_keeps_tx_on_R6: assert property (@(posedge clk) disable iff (rst)
      (tx_wr[i] && !cfg_force_pd[i]) |=> !tx_pd[i]);

    assert_clk_en_mirror_R9: assert property (@(posedge clk) disable iff (rst)
      (tx_clk_en[i] == !tx_pd[i]) && (rx_clk_en[i] == !rx_pd[i]));
  end
endmodule

bind uart_pwr_ctrl uart_pwr_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/uart_pwr_ctrl_tb.sv
module uart_pwr_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] cfg_force_pd, cfg_auto_en, tx_hold_empty, tx_shift_empty, tx_wr;
  logic [NCH-1:0] rx_fifo_empty, rx_idle, rxd_async, ri_async;
  logic [NCH-1:0] tx_pd, rx_pd, tx_clk_en, rx_clk_en, ri_irq;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_pwr_ctrl #(.NUM_CH(NCH)) u_dut (
    .clk(clk), .rst(rst),
    .cfg_force_pd(cfg_force_pd), .cfg_auto_en(cfg_auto_en),
    .tx_hold_empty(tx_hold_empty), .tx_shift_empty(tx_shift_empty), .tx_wr(tx_wr),
    .rx_fifo_empty(rx_fifo_empty), .rx_idle(rx_idle),
    .rxd_async(rxd_async), .ri_async(ri_async),
    .tx_pd(tx_pd), .rx_pd(rx_pd), .tx_clk_en(tx_clk_en), .rx_clk_en(rx_clk_en),
    .ri_irq(ri_irq)
  );

  task automatic check(input string req, input string what,
                       input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // advance n rising edges, then stop at the following falling edge
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic busy_inputs();
    tx_hold_empty  = '0;
    tx_shift_empty = '0;
    tx_wr          = '0;
    rx_fifo_empty  = '0;
    rx_idle        = '0;
  endtask

  // wake everything through a one-cycle auto-enable drop
  task automatic restore();
    busy_inputs();
    cfg_force_pd = '0;
    cfg_auto_en  = '0;
    step(1);
    cfg_auto_en  = '1;
    step(1);
  endtask

  task automatic t_reset();
    check("R9", "reset tx_pd", tx_pd, 2'b00);
    check("R9", "reset rx_pd", rx_pd, 2'b00);
    check("R9", "reset tx_clk_en", tx_clk_en, 2'b11);
    check("R9", "reset rx_clk_en", rx_clk_en, 2'b11);
    check("R9", "reset ri_irq", ri_irq, 2'b00);
  endtask

  task automatic t_tx_entry_and_wake();
    restore();
    tx_hold_empty[0]  = 1'b1;
    tx_shift_empty[0] = 1'b1;
    step(1);
    check("R3", "tx_pd after one idle cycle", tx_pd, 2'b00);
    step(1);
    check("R3", "tx_pd after two idle cycles", tx_pd, 2'b01);
    check("R9", "tx_clk_en in powerdown", tx_clk_en, 2'b10);
    check("R10", "rx_pd unaffected by tx entry", rx_pd, 2'b00);
    tx_wr[0] = 1'b1;
    tx_hold_empty[0] = 1'b0;
    step(1);
    tx_wr[0] = 1'b0;
    check("R6", "tx_pd after host write", tx_pd, 2'b00);
    check("R9", "tx_clk_en after wake", tx_clk_en, 2'b11);
  endtask

  task automatic t_transient();
    restore();
    tx_hold_empty[0]  = 1'b1;
    tx_shift_empty[0] = 1'b1;
    step(1);
    tx_hold_empty[0] = 1'b0;
    step(1);
    tx_hold_empty[0] = 1'b1;
    step(1);
    check("R5", "tx_pd after broken idle run", tx_pd, 2'b00);
    step(1);
    check("R3", "tx_pd after fresh two-cycle run", tx_pd, 2'b01);
  endtask

  task automatic t_write_at_entry();
    restore();
    tx_hold_empty[1]  = 1'b1;
    tx_shift_empty[1] = 1'b1;
    step(1);
    tx_wr[1] = 1'b1;
    step(1);
    tx_wr[1] = 1'b0;
    check("R6", "write in entry cycle keeps tx on", tx_pd, 2'b00);
  endtask

  task automatic t_rx_entry_and_wake();
    restore();
    rx_fifo_empty[1] = 1'b1;
    rx_idle[1]       = 1'b1;
    step(1);
    check("R4", "rx_pd after one idle cycle", rx_pd, 2'b00);
    step(1);
    check("R4", "rx_pd after two idle cycles", rx_pd, 2'b10);
    check("R10", "tx_pd unaffected by rx entry", tx_pd, 2'b00);
    check("R9", "rx_clk_en in powerdown", rx_clk_en, 2'b01);
    rxd_async[1] = ~rxd_async[1];
    step(2);
    check("R7", "rx_pd two edges after line change", rx_pd, 2'b10);
    step(1);
    check("R7", "rx_pd three edges after line change", rx_pd, 2'b00);
    rx_idle[1] = 1'b0;
  endtask

  task automatic t_auto_disabled();
    restore();
    cfg_auto_en    = '0;
    tx_hold_empty  = '1;
    tx_shift_empty = '1;
    rx_fifo_empty  = '1;
    rx_idle        = '1;
    step(4);
    check("R2", "tx_pd with auto disabled", tx_pd, 2'b00);
    check("R2", "rx_pd with auto disabled", rx_pd, 2'b00);
    cfg_auto_en = '1;
    step(2);
    check("R3", "tx_pd both channels after enable", tx_pd, 2'b11);
    check("R4", "rx_pd both channels after enable", rx_pd, 2'b11);
    cfg_auto_en = 2'b10;
    step(1);
    check("R2", "tx_pd after clearing ch0 enable", tx_pd, 2'b10);
    check("R2", "rx_pd after clearing ch0 enable", rx_pd, 2'b10);
  endtask

  task automatic t_force();
    restore();
    cfg_force_pd = 2'b10;
    step(1);
    check("R1", "tx_pd forced ch1", tx_pd, 2'b10);
    check("R1", "rx_pd forced ch1", rx_pd, 2'b10);
    check("R9", "rx_clk_en forced ch1", rx_clk_en, 2'b01);
    tx_wr[1] = 1'b1;
    rxd_async[1] = ~rxd_async[1];
    step(1);
    tx_wr[1] = 1'b0;
    step(3);
    check("R1", "tx_pd forced ignores write", tx_pd, 2'b10);
    check("R1", "rx_pd forced ignores line change", rx_pd, 2'b10);
    cfg_force_pd = '0;
    step(1);
    check("R1", "tx_pd after force release", tx_pd, 2'b00);
  endtask

  task automatic t_ring();
    restore();
    tx_hold_empty[0]  = 1'b1;
    tx_shift_empty[0] = 1'b1;
    rx_fifo_empty[0]  = 1'b1;
    rx_idle[0]        = 1'b1;
    cfg_force_pd[1]   = 1'b1;
    step(2);
    check("R8", "ch0 asleep before ring change", tx_pd & rx_pd, 2'b11);
    ri_async[0] = 1'b0;
    step(2);
    check("R8", "ri_irq two edges after fall", ri_irq, 2'b00);
    step(1);
    check("R8", "ri_irq three edges after fall", ri_irq, 2'b01);
    step(1);
    check("R8", "ri_irq pulse is one cycle", ri_irq, 2'b00);
    check("R8", "ring change does not wake rx", rx_pd, 2'b11);
    ri_async[1] = 1'b0;
    ri_async[0] = 1'b1;
    step(3);
    check("R8", "ri_irq on forced ch1 fall and ch0 rise", ri_irq, 2'b11);
    step(1);
    check("R8", "ri_irq cleared after both pulses", ri_irq, 2'b00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    cfg_force_pd = '0;
    cfg_auto_en  = '1;
    busy_inputs();
    rxd_async = '1;
    ri_async  = '1;
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_tx_entry_and_wake();
    t_transient();
    t_write_at_entry();
    t_rx_entry_and_wake();
    t_auto_disabled();
    t_force();
    t_ring();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule